// File: doc/BRIEF.md
# Transition-Only Capture Recorder

The recorder samples a bus of logic channels on every tick of an internal timebase, but keeps a memory word only when the sampled value differs from the one taken on the tick before. Every kept word carries the channel values and a short stamp. The stamp gives the number of ticks since the word before it, so the full waveform can be rebuilt from far fewer words than a plain sample buffer would need.

A free-running divider sets the tick rate. It emits a one-clock strobe every `period_sel + 1` clocks. An arm pulse starts a run. The run ends on a stop pulse, or by itself when the memory holds its last word. After the run a host reads the memory one word per request through a registered read port, using `word_count` to know how far to read.

If the channels stay still for so long that the stamp field would overflow, the recorder writes a word with unchanged channel values. No elapsed time is lost this way.

Top module: `tcr_recorder`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `word_count` is 0.
- R2: The first tick after an arm always stores a word, with stamp 0 and the current channel values.
- R3: On a later tick while busy, a word is stored only if `chan_in` differs from the value sampled on the previous tick. Each stored word raises `word_count` by one.
- R4: A stored word is 16 bits. Bits [9:0] hold the channel values. Bits [15:10] hold the number of ticks since the previous stored word of the run (1 to 63).
- R5: If 63 ticks pass after a stored word with no change on the channels, the 63rd tick stores a word with the unchanged channel values and stamp 63.
- R6: A sample tick occurs once every `period_sel + 1` clocks. Channel values present between ticks are never sampled.
- R7: When `word_count` reaches 508, the run ends: `busy` falls, `done` rises, and later channel changes leave `word_count` unchanged.
- R8: A stop while busy ends the run: `busy` falls, `done` rises, and a tick in that same cycle is not stored. A stop while not busy has no effect.
- R9: An arm clears `word_count` and `done` and sets `busy`. An arm wins over a stop in the same cycle.
- R10: `rd_data` shows the stored word at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_sel | input | 20 | Timebase terminal count; the tick period is this value plus one clocks |
| arm | input | 1 | Start a new run |
| stop | input | 1 | End the current run |
| chan_in | input | 10 | Monitored channels |
| rd_addr | input | 9 | Memory read address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run has ended (by stop or by a full memory) |
| word_count | output | 9 | Number of words stored in this run |
| rd_data | output | 16 | Registered memory read data |

## Verification
Assertions check several rules on every cycle:
- `word_count` never exceeds the depth and never steps by more than one.
- `done` and `busy` are never high together, and the count is frozen once the run is done.
- The gap counter stays below its wrap limit, and a first tick always writes.
- The timebase never produces back-to-back ticks unless the period is zero.

Other behaviour can only be shown by the bench scenarios, each compared on every clock against a behavioural model:
- the exact words and stamps stored for a given channel pattern;
- channel values between ticks being ignored at a slower period;
- the forced wrap words;
- the arm-over-stop priority;
- the contents read back through the port.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int CHAN_W    = 10;
    localparam int STAMP_W   = 6;
    localparam int DEPTH     = 508;
    localparam int DIV_W     = 20;
    localparam int WORD_W    = CHAN_W + STAMP_W;
    localparam int ADDR_W    = $clog2(DEPTH);
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int STAMP_MAX = (1 << STAMP_W) - 1;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic [CHAN_W-1:0]  chans;
    } rec_word_t;
endpackage

// File: rtl/tcr_timebase.sv
module tcr_timebase import tcr_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period_sel,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt >= period_sel);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period_sel != '0) |=> (!tick || period_sel == '0)); // R6
endmodule

// File: rtl/tcr_change_det.sv
module tcr_change_det import tcr_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              active,
    input  logic              tick,
    input  logic [CHAN_W-1:0] chan_in,
    output logic              wr_en,
    output rec_word_t         wr_word
);
    localparam logic [STAMP_W-1:0] GAP_LIMIT = STAMP_W'(STAMP_MAX - 1);

    typedef struct packed {
        logic               first;
        logic [STAMP_W-1:0] gap;
        logic [CHAN_W-1:0]  prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       changed;
    logic       wrap;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_word = '0;
        changed = (chan_in != st_q.prev);
        wrap    = (st_q.gap == GAP_LIMIT);
        if (arm) begin
            st_d.first = 1'b1;
            st_d.gap   = '0;
        end else if (active && tick) begin
            wr_en         = st_q.first | changed | wrap;
            wr_word.chans = chan_in;
            wr_word.stamp = st_q.first ? '0 : st_q.gap + 1'b1;
            st_d.prev     = chan_in;
            st_d.first    = 1'b0;
            st_d.gap      = wr_en ? '0 : st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gap <= GAP_LIMIT); // R5
    AST_FIRST_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && st_q.first && !arm) |-> wr_en); // R2
endmodule

// File: rtl/tcr_capture_mem.sv
module tcr_capture_mem import tcr_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              stop,
    input  logic              wr_en,
    input  rec_word_t         wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  count,
    output rec_word_t         rd_data
);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_OK  = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic             armed;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        rec_word_t        rdat;
    } mem_state_t;

    mem_state_t st_d, st_q;
    rec_word_t  mem [0:DEPTH-1];
    logic       mem_we;

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (arm) begin
            st_d.armed = 1'b1;
            st_d.fin   = 1'b0;
            st_d.cnt   = '0;
        end else if (stop && st_q.armed) begin
            st_d.armed = 1'b0;
            st_d.fin   = 1'b1;
        end else if (wr_en && st_q.armed) begin
            mem_we   = 1'b1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == FULL_CNT) begin
                st_d.armed = 1'b0;
                st_d.fin   = 1'b1;
            end
        end
        st_d.rdat = (rd_addr <= LAST_OK) ? mem[rd_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[st_q.cnt[ADDR_W-1:0]] <= wr_word;
    end

    assign busy    = st_q.armed;
    assign done    = st_q.fin;
    assign count   = st_q.cnt;
    assign rd_data = st_q.rdat;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (count == $past(count) || count == $past(count) + 1'b1)); // R3
    AST_FROZEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> $stable(count)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R8
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (busy && !done && count == '0)); // R9
endmodule

// File: rtl/tcr_recorder.sv
module tcr_recorder import tcr_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  period_sel,
    input  logic              arm,
    input  logic              stop,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  word_count,
    output logic [WORD_W-1:0] rd_data
);
    logic      tick;
    logic      active;
    logic      wr_en;
    rec_word_t wr_word;
    rec_word_t rd_word;

    assign active  = busy && !stop;
    assign rd_data = rd_word;

    tcr_timebase u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_sel (period_sel),
        .tick       (tick)
    );

    tcr_change_det u_change_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .active  (active),
        .tick    (tick),
        .chan_in (chan_in),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    tcr_capture_mem u_capture_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .stop    (stop),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_addr (rd_addr),
        .busy    (busy),
        .done    (done),
        .count   (word_count),
        .rd_data (rd_word)
    );
endmodule

// File: tb/test_tcr_recorder.sv
module test_tcr_recorder;
    import tcr_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [DIV_W-1:0]  period_sel;
    logic              arm, stop;
    logic [CHAN_W-1:0] chan_in;
    logic [ADDR_W-1:0] rd_addr;
    logic              busy, done;
    logic [CNT_W-1:0]  word_count;
    logic [WORD_W-1:0] rd_data;

    always #4 clk = ~clk;

    tcr_recorder i_tcr_recorder (
        .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .arm(arm), .stop(stop),
        .chan_in(chan_in), .rd_addr(rd_addr), .busy(busy), .done(done),
        .word_count(word_count), .rd_data(rd_data)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    run_cmp = 0;

    // behavioural reference model
    int                 m_div;
    bit                 m_armed, m_done, m_first, m_tick, m_store;
    int                 m_gap;
    logic [CHAN_W-1:0]  m_prev;
    logic [STAMP_W-1:0] m_stamp;
    logic [WORD_W-1:0]  m_mem[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_armed = 0; m_done = 0; m_first = 0; m_gap = 0; m_prev = '0;
            m_mem.delete();
        end else begin
            m_tick = (m_div >= int'(period_sel));
            m_div  = m_tick ? 0 : m_div + 1;
            if (arm) begin
                m_armed = 1; m_done = 0; m_first = 1; m_gap = 0;
                m_mem.delete();
            end else if (stop && m_armed) begin
                m_armed = 0; m_done = 1;
            end else if (m_armed && m_tick) begin
                m_store = m_first || (chan_in != m_prev) || (m_gap == STAMP_MAX - 1);
                if (m_store) begin
                    m_stamp = m_first ? '0 : STAMP_W'(m_gap + 1);
                    m_mem.push_back({m_stamp, chan_in});
                    m_gap = 0;
                    if (m_mem.size() == DEPTH) begin
                        m_armed = 0; m_done = 1;
                    end
                end else begin
                    m_gap = m_gap + 1;
                end
                m_prev  = chan_in;
                m_first = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk(cur_req, "busy", int'(busy), int'(m_armed));
            chk(cur_req, "done", int'(done), int'(m_done));
            chk(cur_req, "word_count", int'(word_count), m_mem.size());
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm();
        arm = 1'b1; step(1); arm = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; step(1); stop = 1'b0;
    endtask

    task automatic read_word(input int addr, output logic [WORD_W-1:0] w);
        rd_addr = ADDR_W'(addr);
        step(1);
        w = rd_data;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] w;
        rst_n = 0; arm = 0; stop = 0; chan_in = '0; period_sel = '0; rd_addr = '0;
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "count after reset", int'(word_count), 0);
        run_cmp = 1;

        // R2 R3 R4: first word, hold, then a change
        cur_req = "R3";
        chan_in = 10'h005;
        pulse_arm();
        step(3);
        chan_in = 10'h02A;
        step(1);
        pulse_stop();
        chk("R3", "count after two-value run", int'(word_count), 2);
        chk("R8", "done after stop", int'(done), 1);
        read_word(0, w);
        chk("R2", "first word", int'(w), int'({6'd0, 10'h005}));
        read_word(1, w);
        chk("R4", "second word stamp and chans", int'(w), int'({6'd3, 10'h02A}));

        // R8: stop while idle has no effect
        cur_req = "R8";
        chan_in = 10'h111;
        pulse_stop();
        step(2);
        chk("R8", "count after idle stop", int'(word_count), 2);
        chk("R8", "done after idle stop", int'(done), 1);

        // R5: long quiet interval forces wrap words
        cur_req = "R5";
        chan_in = 10'h3FF;
        pulse_arm();
        step(130);
        pulse_stop();
        chk("R5", "count after quiet run", int'(word_count), 3);
        read_word(1, w);
        chk("R5", "wrap word", int'(w), int'({6'd63, 10'h3FF}));
        read_word(2, w);
        chk("R5", "second wrap word", int'(w), int'({6'd63, 10'h3FF}));

        // R6: slower timebase, channels move every clock
        cur_req = "R6";
        period_sel = DIV_W'(3);
        pulse_arm();
        for (int i = 0; i < 80; i++) begin
            chan_in = CHAN_W'((i * 37) >> 3);
            step(1);
        end
        pulse_stop();
        chk("R6", "count bounded by ticks", int'(word_count <= 21), 1);
        for (int i = 0; i < m_mem.size(); i++) begin
            read_word(i, w);
            chk("R10", "readback slow run", int'(w), int'(m_mem[i]));
        end

        // R9: arm and stop in the same cycle
        cur_req = "R9";
        period_sel = '0;
        arm = 1'b1; stop = 1'b1;
        step(1);
        arm = 1'b0; stop = 1'b0;
        chk("R9", "busy after arm+stop", int'(busy), 1);
        chk("R9", "done after arm+stop", int'(done), 0);
        pulse_stop();

        // R7: fill the memory
        cur_req = "R7";
        pulse_arm();
        for (int i = 0; i < 520; i++) begin
            chan_in = ~chan_in;
            step(1);
        end
        chk("R7", "count at full", int'(word_count), DEPTH);
        chk("R7", "done at full", int'(done), 1);
        chk("R7", "busy at full", int'(busy), 0);
        for (int i = 0; i < 10; i++) begin
            chan_in = CHAN_W'(i * 5);
            step(1);
        end
        chk("R7", "count frozen after full", int'(word_count), DEPTH);

        // R10: full readback
        cur_req = "R10";
        for (int i = 0; i < m_mem.size(); i++) begin
            read_word(i, w);
            chk("R10", "readback full run", int'(w), int'(m_mem[i]));
        end
        read_word(5, w);
        chk("R4", "stamp of toggling run", int'(w[WORD_W-1:CHAN_W]), 1);

        run_cmp = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule